// File: doc/BRIEF.md
# Scanline-Counting Interrupt Generator

The block follows the rendered lines of a raster video processor and interrupts a CPU once a programmed number of lines has gone by in the current frame. It is fed the video processor's rendering-enabled flag and a strobe that comes with the current line number. The block keeps the last line number it saw, so a strobe counts only when the line number differs from that stored value. On the first visible line of each frame, the block clears its own counter. It also reports whether the raster is inside the visible part of a frame.

Software writes an 8-bit line target and an interrupt-enable bit. It polls or acknowledges through a status read. That read returns the pending and in-frame flags and then clears pending. The interrupt line is high exactly while a match is pending and interrupts are enabled. So enabling interrupts while a match is already pending raises the line at once, and disabling them drops it.

Top module: `scanline_irq_gen`

## Requirements
- R1: After reset, `irq` is 0, `stat_byte` is 0x00, the target is 0, interrupts are disabled, and the stored line number is -1. As a result, the first strobe with line 0 starts a frame.
- R2: While `render_en` is 0, strobes are ignored: no count and no stored line update. The in-frame flag is cleared on the next clock. The pending flag is kept.
- R3: A strobe with a new line number that is below 0 or above 238 clears the in-frame flag.
- R4: A strobe with a new line number from 0 to 238 while not in frame sets in-frame, loads the counter with 0 and clears pending.
- R5: A strobe with a new line number from 0 to 238 while in frame increments the 8-bit counter. If the incremented value equals the target, pending is set.
- R6: A strobe whose line number equals the stored one changes nothing.
- R7: A write with `cfg_wr_sel`=1 loads the enable from data bit 7. `irq` equals pending AND enable. Enabling while pending raises `irq` on the next clock, and disabling drops it.
- R8: `stat_byte` bit 7 is pending, bit 6 is in-frame, and bits 5..0 are 0. A cycle with `stat_rd` clears pending, except when a match sets it in the same cycle, in which case the match wins.
- R9: A write with `cfg_wr_sel`=0 loads the target from all 8 data bits. A target of 0 never produces a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| render_en | input | 1 | Background or sprite rendering enabled |
| line_strobe | input | 1 | Line-number sample valid |
| line_num | input | 9 | Current line, signed (-1 is pre-render) |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_sel | input | 1 | 0 = target, 1 = control (bit 7 enable) |
| cfg_wr_data | input | 8 | Write data |
| stat_rd | input | 1 | Status read; acknowledges pending |
| irq | output | 1 | Interrupt request, active high |
| stat_byte | output | 8 | {pending, in_frame, 6'b0} |

## Verification
The bound checker watches several rules on every cycle:
- `irq` never rises without pending.
- The low status bits stay zero.
- Each counted line adds exactly one to the counter.
- A frame start leaves the counter at zero and pending clear.
- A read without a coincident match clears pending.
- Disabled rendering or an out-of-range line drops in-frame.
- A repeated line number leaves the counter still.
- A zero target never matches.

Some behaviour only the bench's scenarios can show:
- The exact line on which a match fires after a frame restart.
- A pending match surviving a rendering pause.
- The match-beats-read ordering as seen at the status port.
- The -1 reset value of the stored line.

// File: rtl/slirq_pkg.sv
package slirq_pkg;
  typedef enum logic {
    SEL_TARGET = 1'b0,
    SEL_CTRL   = 1'b1
  } cfg_sel_e;

  localparam int STAT_PEND_BIT  = 7;
  localparam int STAT_FRAME_BIT = 6;
endpackage

// File: rtl/sl_frame_track.sv
module sl_frame_track #(
  parameter int LINE_W    = 9,
  parameter int LAST_LINE = 238
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     render_en,
  input  logic                     line_strobe,
  input  logic signed [LINE_W-1:0] line_num,
  output logic                     in_frame,
  output logic                     line_chg,
  output logic                     line_outside,
  output logic                     frame_start,
  output logic                     line_tick
);
  logic signed [LINE_W-1:0] prev_line;

  function automatic logic outside_visible(input logic signed [LINE_W-1:0] ln);
    return (ln < 0) || (ln > LAST_LINE);
  endfunction

  assign line_chg     = render_en && line_strobe && (line_num != prev_line);
  assign line_outside = outside_visible(line_num);
  assign frame_start  = line_chg && !line_outside && !in_frame;
  assign line_tick    = line_chg && !line_outside && in_frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_line <= '1;
      in_frame  <= 1'b0;
    end else if (!render_en) begin
      in_frame  <= 1'b0;
    end else if (line_chg) begin
      prev_line <= line_num;
      in_frame  <= !line_outside;
    end
  end
endmodule

// File: rtl/sl_line_count.sv
module sl_line_count #(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              line_tick,
  input  logic              tgt_wr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  target,
  output logic              hit
);
  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c);
    return c + 1'b1;
  endfunction

  assign hit = line_tick && (bump(count) == target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      target <= '0;
    end else begin
      if (frame_start)    count <= '0;
      else if (line_tick) count <= bump(count);
      if (tgt_wr)         target <= wr_data[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/sl_irq_ctrl.sv
module sl_irq_ctrl #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              hit,
  input  logic              stat_rd,
  input  logic              ctrl_wr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              pending,
  output logic              enable,
  output logic              irq
);
  assign irq = pending && enable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      enable  <= 1'b0;
    end else begin
      if (frame_start)  pending <= 1'b0;
      else if (hit)     pending <= 1'b1;
      else if (stat_rd) pending <= 1'b0;
      if (ctrl_wr)      enable  <= wr_data[DATA_W-1];
    end
  end
endmodule

// File: rtl/scanline_irq_gen.sv
module scanline_irq_gen #(
  parameter int CNT_W     = 8,
  parameter int DATA_W    = 8,
  parameter int LINE_W    = 9,
  parameter int LAST_LINE = 238
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     render_en,
  input  logic                     line_strobe,
  input  logic signed [LINE_W-1:0] line_num,
  input  logic                     cfg_wr_en,
  input  logic                     cfg_wr_sel,
  input  logic [DATA_W-1:0]        cfg_wr_data,
  input  logic                     stat_rd,
  output logic                     irq,
  output logic [DATA_W-1:0]        stat_byte
);
  import slirq_pkg::*;

  logic             in_frame, line_chg, line_outside, frame_start, line_tick;
  logic [CNT_W-1:0] count, target;
  logic             hit, pending, enable;
  logic             tgt_wr, ctrl_wr;

  assign tgt_wr  = cfg_wr_en && (cfg_sel_e'(cfg_wr_sel) == SEL_TARGET);
  assign ctrl_wr = cfg_wr_en && (cfg_sel_e'(cfg_wr_sel) == SEL_CTRL);

  sl_frame_track #(.LINE_W(LINE_W), .LAST_LINE(LAST_LINE)) u_track (
    .clk(clk), .rst_n(rst_n), .render_en(render_en), .line_strobe(line_strobe),
    .line_num(line_num), .in_frame(in_frame), .line_chg(line_chg),
    .line_outside(line_outside), .frame_start(frame_start), .line_tick(line_tick)
  );

  sl_line_count #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_count (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_tick(line_tick),
    .tgt_wr(tgt_wr), .wr_data(cfg_wr_data), .count(count), .target(target), .hit(hit)
  );

  sl_irq_ctrl #(.DATA_W(DATA_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .hit(hit),
    .stat_rd(stat_rd), .ctrl_wr(ctrl_wr), .wr_data(cfg_wr_data),
    .pending(pending), .enable(enable), .irq(irq)
  );

  always_comb begin
    stat_byte                 = '0;
    stat_byte[STAT_PEND_BIT]  = pending;
    stat_byte[STAT_FRAME_BIT] = in_frame;
  end
endmodule

// File: rtl/scanline_irq_chk.sv
module scanline_irq_chk #(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              render_en,
  input logic              line_strobe,
  input logic              cfg_wr_en,
  input logic              cfg_wr_sel,
  input logic [DATA_W-1:0] cfg_wr_data,
  input logic              stat_rd,
  input logic              irq,
  input logic [DATA_W-1:0] stat_byte,
  input logic              line_chg,
  input logic              line_outside,
  input logic              frame_start,
  input logic              line_tick,
  input logic              hit,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  target
);
  assert_render_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !render_en |=> !stat_byte[6]);

  assert_outside_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
    line_chg && line_outside |=> !stat_byte[6]);

  assert_frame_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> stat_byte[6] && !stat_byte[7] && (count == '0));

  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    line_tick |=> count == CNT_W'($past(count) + 1'b1));

  assert_same_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
    line_strobe && !line_chg |=> $stable(count));

  assert_irq_needs_pend_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> stat_byte[7]);

  assert_enable_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en && cfg_wr_sel && cfg_wr_data[DATA_W-1] && stat_byte[7]
      && !stat_rd && !frame_start |=> irq);

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !hit |=> !stat_byte[7]);

  assert_low_bits_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_byte[5:0] == '0);

  assert_zero_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (target == '0) |-> !hit);
endmodule

bind scanline_irq_gen scanline_irq_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .render_en(render_en), .line_strobe(line_strobe),
  .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel), .cfg_wr_data(cfg_wr_data),
  .stat_rd(stat_rd), .irq(irq), .stat_byte(stat_byte), .line_chg(line_chg),
  .line_outside(line_outside), .frame_start(frame_start), .line_tick(line_tick),
  .hit(hit), .count(count), .target(target)
);

// File: tb/test_scanline_irq_gen.sv
`timescale 1ns/1ps
module test_scanline_irq_gen;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              render_en = 1'b0;
  logic              line_strobe = 1'b0;
  logic signed [8:0] line_num = '0;
  logic              cfg_wr_en = 1'b0;
  logic              cfg_wr_sel = 1'b0;
  logic [7:0]        cfg_wr_data = '0;
  logic              stat_rd = 1'b0;
  logic              irq;
  logic [7:0]        stat_byte;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  scanline_irq_gen i_scanline_irq_gen (
    .clk(clk), .rst_n(rst_n), .render_en(render_en), .line_strobe(line_strobe),
    .line_num(line_num), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
    .cfg_wr_data(cfg_wr_data), .stat_rd(stat_rd), .irq(irq), .stat_byte(stat_byte)
  );

  // fields: req[34:31] rend[30] strb[29] line[28:20] wr[19] sel[18] data[17:10] rd[9] irq[8] stat[7:0]
  localparam int NV = 35;
  localparam logic [34:0] VEC [0:NV-1] = '{
    {4'd9, 1'b1,1'b0,9'd0,   1'b1,1'b0,8'h03, 1'b0, 1'b0,8'h00}, // R9 target=3
    {4'd7, 1'b1,1'b0,9'd0,   1'b1,1'b1,8'h80, 1'b0, 1'b0,8'h00}, // R7 enable
    {4'd3, 1'b1,1'b1,9'h1FF, 1'b0,1'b0,8'h00, 1'b0, 1'b0,8'h00}, // R3 line -1
    {4'd4, 1'b1,1'b1,9'd0,   1'b0,1'b0,8'h00, 1'b0, 1'b0,8'h40}, // R4 frame start
    {4'd6, 1'b1,1'b1,9'd0,   1'b0,1'b0,8'h00, 1'b0, 1'b0,8'h40}, // R6 repeat line
    {4'd5, 1'b1,1'b1,9'd1,   1'b0,1'b0,8'h00, 1'b0, 1'b0,8'h40},
    {4'd5, 1'b1,1'b1,9'd2,   1'b0,1'b0,8'h00, 1'b0, 1'b0,8'h40},
    {4'd5, 1'b1,1'b1,9'd3,   1'b0,1'b0,8'h00, 1'b0, 1'b1,8'hC0}, // R5 match
    {4'd8, 1'b1,1'b0,9'd3,   1'b0,1'b0,8'h00, 1'b1, 1'b0,8'h40}, // R8 read acks
    {4'd7, 1'b1,1'b0,9'd3,   1'b1,1'b1,8'h00, 1'b0, 1'b0,8'h40}, // R7 disable
    {4'd5, 1'b1,1'b1,9'd4,   1'b0,1'b0,8'h00, 1'b0, 1'b0,8'h40},
    {4'd9, 1'b1,1'b0,9'd4,   1'b1,1'b0,8'h06, 1'b0, 1'b0,8'h40}, // R9 target=6
    {4'd5, 1'b1,1'b1,9'd5,   1'b0,1'b0,8'h00, 1'b0, 1'b0,8'h40},
    {4'd7, 1'b1,1'b1,9'd6,   1'b0,1'b0,8'h00, 1'b0, 1'b0,8'hC0}, // R7 masked
    {4'd7, 1'b1,1'b0,9'd6,   1'b1,1'b1,8'h80, 1'b0, 1'b1,8'hC0}, // R7 enable while pending
    {4'd7, 1'b1,1'b0,9'd6,   1'b1,1'b1,8'h00, 1'b0, 1'b0,8'hC0},
    {4'd7, 1'b1,1'b0,9'd6,   1'b1,1'b1,8'h80, 1'b0, 1'b1,8'hC0},
    {4'd2, 1'b0,1'b0,9'd6,   1'b0,1'b0,8'h00, 1'b0, 1'b1,8'h80}, // R2 render off
    {4'd2, 1'b0,1'b1,9'd7,   1'b0,1'b0,8'h00, 1'b0, 1'b1,8'h80}, // R2 strobe ignored
    {4'd3, 1'b1,1'b1,9'd239, 1'b0,1'b0,8'h00, 1'b0, 1'b1,8'h80},
    {4'd4, 1'b1,1'b1,9'd0,   1'b0,1'b0,8'h00, 1'b0, 1'b0,8'h40}, // R4 clears pending
    {4'd3, 1'b1,1'b1,9'd239, 1'b0,1'b0,8'h00, 1'b0, 1'b0,8'h00}, // R3 leave frame
    {4'd4, 1'b1,1'b1,9'd0,   1'b0,1'b0,8'h00, 1'b0, 1'b0,8'h40},
    {4'd5, 1'b1,1'b1,9'd1,   1'b0,1'b0,8'h00, 1'b0, 1'b0,8'h40},
    {4'd5, 1'b1,1'b1,9'd2,   1'b0,1'b0,8'h00, 1'b0, 1'b0,8'h40},
    {4'd5, 1'b1,1'b1,9'd3,   1'b0,1'b0,8'h00, 1'b0, 1'b0,8'h40},
    {4'd5, 1'b1,1'b1,9'd4,   1'b0,1'b0,8'h00, 1'b0, 1'b0,8'h40},
    {4'd5, 1'b1,1'b1,9'd5,   1'b0,1'b0,8'h00, 1'b0, 1'b0,8'h40},
    {4'd5, 1'b1,1'b1,9'd6,   1'b0,1'b0,8'h00, 1'b0, 1'b1,8'hC0}, // R5 after restart
    {4'd9, 1'b1,1'b0,9'd6,   1'b1,1'b0,8'h08, 1'b0, 1'b1,8'hC0},
    {4'd8, 1'b1,1'b1,9'd7,   1'b0,1'b0,8'h00, 1'b1, 1'b0,8'h40},
    {4'd8, 1'b1,1'b1,9'd8,   1'b0,1'b0,8'h00, 1'b1, 1'b1,8'hC0}, // R8 match beats read
    {4'd9, 1'b1,1'b0,9'd8,   1'b1,1'b0,8'h00, 1'b1, 1'b0,8'h40},
    {4'd9, 1'b1,1'b1,9'd9,   1'b0,1'b0,8'h00, 1'b0, 1'b0,8'h40},
    {4'd3, 1'b1,1'b1,9'h1FF, 1'b0,1'b0,8'h00, 1'b0, 1'b0,8'h00}  // R3 negative line
  };

  task automatic check(input int req, input logic exp_irq, input logic [7:0] exp_stat);
    checks++;
    if (irq !== exp_irq || stat_byte !== exp_stat) begin
      errors++;
      $display("FAIL R%0d: irq=%0b stat=%02h expected irq=%0b stat=%02h",
               req, irq, stat_byte, exp_irq, exp_stat);
    end
  endtask

  task automatic step(input logic r, input logic s, input logic signed [8:0] ln,
                      input logic w, input logic sel, input logic [7:0] d, input logic rd);
    render_en = r; line_strobe = s; line_num = ln;
    cfg_wr_en = w; cfg_wr_sel = sel; cfg_wr_data = d; stat_rd = rd;
    @(posedge clk); #1;
    line_strobe = 1'b0; cfg_wr_en = 1'b0; stat_rd = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(1, 1'b0, 8'h00); // R1 reset state
    rst_n = 1'b1;
    @(posedge clk); #1;
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][30], VEC[i][29], VEC[i][28:20], VEC[i][19], VEC[i][18],
           VEC[i][17:10], VEC[i][9]);
      check(int'(VEC[i][34:31]), VEC[i][8], VEC[i][7:0]);
    end
    // R1: reset in mid-frame with a pending match
    step(1, 1, 9'd0, 0, 0, 8'h00, 0);
    step(1, 0, 9'd0, 1, 0, 8'h01, 0);
    step(1, 0, 9'd0, 1, 1, 8'h80, 0);
    step(1, 1, 9'd1, 0, 0, 8'h00, 0);
    check(5, 1'b1, 8'hC0);
    rst_n = 1'b0; #2;
    check(1, 1'b0, 8'h00);
    @(posedge clk); #1;
    rst_n = 1'b1;
    // R1: stored line is -1, so line 0 starts a frame; enable was cleared
    step(1, 1, 9'd0, 0, 0, 8'h00, 0);
    check(1, 1'b0, 8'h40);
    // R9: target is 0 after reset and never matches
    step(1, 0, 9'd0, 1, 1, 8'h80, 0);
    for (int k = 1; k <= 5; k++) begin
      step(1, 1, 9'(k), 0, 0, 8'h00, 0);
      check(9, 1'b0, 8'h40);
    end
    // R2: pause keeps the counter: target 7 with count 5, pause, then line 6 restarts frame
    step(1, 0, 9'd5, 1, 0, 8'h07, 0);
    step(0, 1, 9'd6, 0, 0, 8'h00, 0);
    check(2, 1'b0, 8'h00);
    step(1, 1, 9'd6, 0, 0, 8'h00, 0);
    check(2, 1'b0, 8'h40);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule